// File: doc/BRIEF.md
# Page Access Permission Checker

This block sits behind the address translation lookup of a memory management unit. It decides, for each access request, whether the access may proceed or which exception it raises. It is told four things for each request. The first is whether virtual mode is on. The second is whether the requester runs in user or privileged mode. The third is the kind of access: load, store or instruction fetch. The fourth is the result of the translation lookup: a hit flag, the zone index of the matching entry, and the entry's writable, executable and guarded attribute bits.

A zone protection register holds a 2-bit access field for each zone. Software writes it as one word. The zone field can deny a user access outright. It can also lift the writable and executable restrictions of a page. The modes lift them differently: in user mode only field value 11 lifts them, while in privileged mode 10 and 11 both do. A guarded page can never be fetched from, whatever the zone field says. The verdict appears one clock after the request as four registered flags. The flags are data storage, instruction storage, data lookup miss and instruction lookup miss, and at most one of them is set.

Top module: `mmu_perm_check`

## Requirements
- R1: While `vm_en` is 0, no exception flag is raised for any request, whatever the other inputs.
- R2: The flags are registered. The verdict for a request presented at a rising edge with `req_valid` high appears after that edge. A cycle with `req_valid` low, or with `acc_kind` = 11 (no access), gives all flags 0 after the edge. `acc_kind` encodes 00 = load, 01 = store, 10 = fetch.
- R3: When `tlb_hit` is 0, a load or store raises only `exc_dmiss`, and a fetch raises only `exc_imiss`. A miss takes priority over every storage exception.
- R4: In user mode (`user_mode` = 1), a zone field of 00 denies the access. A load or store raises `exc_dstore`, and a fetch raises `exc_istore`.
- R5: In user mode, a store to a page with `pg_wr` = 0 raises `exc_dstore` unless the zone field is 11.
- R6: In privileged mode, a store to a page with `pg_wr` = 0 raises `exc_dstore` unless the zone field is 10 or 11.
- R7: A fetch from a page with `pg_ex` = 0 raises `exc_istore` unless the zone field is 11 (user mode) or 10 or 11 (privileged mode).
- R8: A fetch from a page with `pg_guard` = 1 raises `exc_istore` in both modes, whatever the zone field.
- R9: A privileged load is never denied. No load depends on `pg_wr`, `pg_ex` or `pg_guard`.
- R10: The zone register holds 16 fields of 2 bits. Zone n sits at bits [31-2n:30-2n], so zone 0 is the most significant pair. The register is loaded whole from `zpr_wdata` at a rising edge with `zpr_we` high, and it resets to all zeros. `tlb_zone` selects the field that applies.
- R11: At most one exception flag is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zpr_we | input | 1 | Zone register write enable |
| zpr_wdata | input | 32 | Zone register write word |
| req_valid | input | 1 | Access request present |
| vm_en | input | 1 | Virtual mode enable |
| user_mode | input | 1 | 1 = user, 0 = privileged |
| acc_kind | input | 2 | 00 load, 01 store, 10 fetch, 11 none |
| tlb_hit | input | 1 | Valid matching translation entry found |
| tlb_zone | input | 4 | Zone index of the entry |
| pg_wr | input | 1 | Page writable attribute |
| pg_ex | input | 1 | Page executable attribute |
| pg_guard | input | 1 | Page guarded attribute |
| exc_dstore | output | 1 | Data storage exception |
| exc_istore | output | 1 | Instruction storage exception |
| exc_dmiss | output | 1 | Data lookup miss exception |
| exc_imiss | output | 1 | Instruction lookup miss exception |

## Verification
The bench builds the block with its default parameters: 16 zones selected by a 4-bit index. With these values, every zone field position in the 32-bit write word can be reached, including the most and least significant pairs. Directed cases step through all four zone field values in both modes for each access kind and each attribute bit. Random cases then mix in changes to the zone word, disabled virtual mode, idle cycles and lookup misses.

// File: rtl/mmu_perm_check.sv
module mmu_perm_check #(
  parameter int ZONES = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      zpr_we,
  input  logic [2*ZONES-1:0]        zpr_wdata,
  input  logic                      req_valid,
  input  logic                      vm_en,
  input  logic                      user_mode,
  input  logic [1:0]                acc_kind,
  input  logic                      tlb_hit,
  input  logic [$clog2(ZONES)-1:0]  tlb_zone,
  input  logic                      pg_wr,
  input  logic                      pg_ex,
  input  logic                      pg_guard,
  output logic                      exc_dstore,
  output logic                      exc_istore,
  output logic                      exc_dmiss,
  output logic                      exc_imiss
);
  localparam int ZW = $clog2(ZONES);
  localparam int RW = 2 * ZONES;

  logic [RW-1:0] zpr_q;
  logic [1:0]    zfield;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      zpr_q <= '0;
    else if (zpr_we) zpr_q <= zpr_wdata;

  always_comb begin
    zfield = 2'b00;
    for (int i = 0; i < ZONES; i++)
      if (tlb_zone == ZW'(i)) zfield = zpr_q[2*(ZONES-1-i) +: 2];
  end

  wire is_ld   = acc_kind == 2'b00;
  wire is_st   = acc_kind == 2'b01;
  wire is_fe   = acc_kind == 2'b10;
  wire is_data = is_ld | is_st;
  wire act     = req_valid & vm_en;

  wire z_deny  = user_mode & (zfield == 2'b00);
  wire z_lift  = user_mode ? (zfield == 2'b11) : zfield[1];

  wire d_miss  = act & is_data & ~tlb_hit;
  wire i_miss  = act & is_fe & ~tlb_hit;
  wire d_deny  = act & is_data & tlb_hit &
                 (z_deny | (is_st & ~pg_wr & ~z_lift));
  wire i_deny  = act & is_fe & tlb_hit &
                 (z_deny | pg_guard | (~pg_ex & ~z_lift));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {exc_dstore, exc_istore, exc_dmiss, exc_imiss} <= '0;
    else        {exc_dstore, exc_istore, exc_dmiss, exc_imiss} <= {d_deny, i_deny, d_miss, i_miss};

  a_r1_vm_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!vm_en) |=> !(exc_dstore | exc_istore | exc_dmiss | exc_imiss));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || acc_kind == 2'b11) |=> !(exc_dstore | exc_istore | exc_dmiss | exc_imiss));

  a_r3_data_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && vm_en && !tlb_hit && acc_kind[1] == 1'b0) |=> (exc_dmiss && !exc_dstore));

  a_r3_fetch_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && vm_en && !tlb_hit && acc_kind == 2'b10) |=> (exc_imiss && !exc_istore));

  a_r8_guard_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && vm_en && tlb_hit && acc_kind == 2'b10 && pg_guard) |=> exc_istore);

  a_r9_priv_load_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && vm_en && tlb_hit && acc_kind == 2'b00 && !user_mode) |=> !exc_dstore);

  a_r11_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({exc_dstore, exc_istore, exc_dmiss, exc_imiss}));
endmodule

// File: tb/tb_mmu_perm_check.sv
module tb_mmu_perm_check;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic zpr_we = 1'b0;
  logic [31:0] zpr_wdata = '0;
  logic req_valid = 1'b0, vm_en = 1'b0, user_mode = 1'b0;
  logic [1:0] acc_kind = 2'b00;
  logic tlb_hit = 1'b0;
  logic [3:0] tlb_zone = '0;
  logic pg_wr = 1'b0, pg_ex = 1'b0, pg_guard = 1'b0;
  logic exc_dstore, exc_istore, exc_dmiss, exc_imiss;

  int n_vec = 0, n_bad = 0;
  logic [31:0] zmodel = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmu_perm_check dut (
    .clk, .rst_n, .zpr_we, .zpr_wdata, .req_valid, .vm_en, .user_mode,
    .acc_kind, .tlb_hit, .tlb_zone, .pg_wr, .pg_ex, .pg_guard,
    .exc_dstore, .exc_istore, .exc_dmiss, .exc_imiss
  );

  function automatic logic [1:0] zf(input logic [31:0] z, input logic [3:0] n);
    return z[31 - 2*n -: 2];
  endfunction

  // order {dstore, istore, dmiss, imiss}
  function automatic logic [3:0] expect_flags(
      input logic v, input logic vm, input logic u, input logic [1:0] k,
      input logic h, input logic [1:0] f, input logic w, input logic x, input logic g);
    logic lift;
    if (!v || !vm || k == 2'b11) return 4'b0000;
    if (!h) return (k == 2'b10) ? 4'b0001 : 4'b0010;
    lift = u ? (f == 2'b11) : (f == 2'b10 || f == 2'b11);
    case (k)
      2'b00: return (u && f == 2'b00) ? 4'b1000 : 4'b0000;
      2'b01: return ((u && f == 2'b00) || (!w && !lift)) ? 4'b1000 : 4'b0000;
      default: return ((u && f == 2'b00) || g || (!x && !lift)) ? 4'b0100 : 4'b0000;
    endcase
  endfunction

  function automatic string tag_of(input logic v, input logic vm, input logic [1:0] k,
      input logic h, input logic u, input logic g);
    if (!vm) return "R1";
    if (!v || k == 2'b11) return "R2";
    if (!h) return "R3";
    if (k == 2'b00) return u ? "R4" : "R9";
    if (k == 2'b01) return u ? "R5" : "R6";
    if (g) return "R8";
    return "R7";
  endfunction

  task automatic check(input logic [3:0] exp, input string tag);
    logic [3:0] act;
    act = {exc_dstore, exc_istore, exc_dmiss, exc_imiss};
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: flags got %b expected %b", tag, act, exp);
    end
    if ($countones(act) > 1) begin
      n_bad++;
      $display("FAIL R11: flags got %b expected at most one set", act);
    end
  endtask

  task automatic write_zpr(input logic [31:0] w);
    @(negedge clk);
    zpr_we = 1'b1; zpr_wdata = w; req_valid = 1'b0;
    @(negedge clk);
    zpr_we = 1'b0; zmodel = w;
  endtask

  task automatic access(input logic v, input logic vm, input logic u, input logic [1:0] k,
      input logic h, input logic [3:0] zn, input logic w, input logic x, input logic g,
      input string tagov);
    logic [3:0] e;
    string t;
    @(negedge clk);
    req_valid = v; vm_en = vm; user_mode = u; acc_kind = k; tlb_hit = h;
    tlb_zone = zn; pg_wr = w; pg_ex = x; pg_guard = g;
    e = expect_flags(v, vm, u, k, h, zf(zmodel, zn), w, x, g);
    t = (tagov != "") ? tagov : tag_of(v, vm, k, h, u, g);
    @(negedge clk);
    check(e, t);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: run got hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check(4'b0000, "R2 reset");
    rst_n = 1'b1;
    // R10: reset zone word is zero, so user load is denied, privileged load passes
    access(1, 1, 1, 2'b00, 1, 4'd7, 1, 1, 0, "R10 reset zones");
    access(1, 1, 0, 2'b00, 1, 4'd7, 0, 0, 1, "R9");
    // R10: zone 0 at MSBs
    write_zpr(32'hC000_0000);
    access(1, 1, 1, 2'b01, 1, 4'd0, 0, 1, 0, "R10 zone0 msb");
    access(1, 1, 1, 2'b01, 1, 4'd1, 1, 1, 0, "R10 zone1 denied");
    write_zpr(32'h0000_0003);
    access(1, 1, 1, 2'b10, 1, 4'd15, 1, 0, 0, "R10 zone15 lsb");
    access(1, 1, 1, 2'b10, 1, 4'd14, 1, 1, 0, "R10 zone14 denied");
    // Sweep field values per zone: zones 0..3 = 00,01,10,11
    write_zpr(32'h1B1B_1B1B);
    for (int zn = 0; zn < 4; zn++)
      for (int u = 0; u < 2; u++)
        for (int k = 0; k < 4; k++)
          for (int a = 0; a < 8; a++)
            access(1, 1, u[0], k[1:0], 1, zn[3:0], a[0], a[1], a[2], "");
    // R1, R2, R3 directed
    access(1, 0, 1, 2'b01, 0, 4'd0, 0, 0, 1, "R1");
    access(0, 1, 1, 2'b10, 1, 4'd0, 0, 0, 1, "R2 idle");
    access(1, 1, 1, 2'b01, 0, 4'd0, 0, 0, 0, "R3 data miss");
    access(1, 1, 0, 2'b10, 0, 4'd3, 0, 0, 1, "R3 fetch miss");
    // Random
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[31:28] == 4'h0) write_zpr($urandom);
      access(r[0] | r[1], r[2] | r[3] | r[4], r[5], r[7:6], r[8] | r[9] | r[10],
             r[14:11], r[15], r[16], r[17] & r[18], "");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule